// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block collects the sticky event flags of four event groups (power, detection, fault and supply) and condenses them into an 8-bit interrupt summary. Every group is a sticky register. A one-cycle set pulse from the monitoring logic sets a bit, and the bit stays set until software issues the global clear command. Six summary bits each mirror one chosen event bit. One summary bit is the OR of the whole supply group. One position is reserved.

A per-bit mask chooses which summary bits may assert the active-low interrupt pin. A global enable either drives the pin or releases it to high impedance. The pin is presented as a data value plus an output enable, for a pad cell outside the block. Software reaches the summary, mask, enable, clear command and the four event groups through a small 3-bit-address register port. Writes take effect at the clock edge and reads are combinational.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the summary (addr 0), mask (addr 1) and all four event registers (addr 4 power, 5 detect, 6 fault, 7 supply) read 0x00, and the control register (addr 2) reads 0x80 (enable set). The pin is driven (`irq_oe`=1) and `irq_do` is 1.
- R2: A 1 on bit i of an event set input sets bit i of that event register at the next clock edge. The bit stays 1 until a clear command, and set pulses on several bits accumulate.
- R3: The summary bits are laid out as follows:
  - bit0 = power bit0
  - bit1 = power bit4
  - bit2 = fault bit4
  - bit3 = detect bit0
  - bit4 = detect bit4
  - bit5 = fault bit0
  - bit7 = OR of all supply bits
  - bit6 always reads 0

  No other event bit affects the summary.
- R4: `irq_do` is 0 when some summary bit is 1 and its mask bit is 0. It is 1 otherwise.
- R5: A summary bit whose mask bit (addr 1, same position) is 1 never drives `irq_do` low.
- R6: Control register bit 7 is the global enable. Writing it 0 sets `irq_oe` to 0 (pin released), and writing it 1 sets `irq_oe` to 1. The other control bits read 0.
- R7: Writing a value with bit 7 set to addr 3 clears all four event registers, and so the summary, at the next edge. Mask and enable are kept, and addr 3 always reads 0x00.
- R8: If an event set pulse arrives in the same cycle as a clear command, the pulsed bits are 1 after the edge, and all other event bits are 0.
- R9: Writes to the summary and to the event registers (addr 0, 4 to 7) change nothing.
- R10: A write to addr 3 with bit 7 equal to 0 clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_set | input | 8 | Power event set pulses, one per bit |
| det_set | input | 8 | Detection event set pulses |
| flt_set | input | 8 | Fault event set pulses |
| sup_set | input | 8 | Supply event set pulses |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_do | output | 1 | Interrupt pin data, 0 = interrupt asserted |
| irq_oe | output | 1 | Interrupt pin output enable, 0 = high impedance |

## Verification
The two functions that can fall in the same cycle are the clear command and an event set pulse. They meet at one clock edge in the sticky registers. The bench provokes the collision by preloading bits in all four groups. It then drives a clear write and a detect set pulse in the same cycle. It judges the result by reading every event register and the summary after that edge. Only the pulsed bit must survive, and the pin must still reflect it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SUM  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PWR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DET  = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLT  = 3'd6;
  localparam logic [ADDR_W-1:0] A_SUP  = 3'd7;

  // command / enable bit in control and clear registers
  localparam int unsigned CMD_BIT = 7;

  // summary positions
  localparam int unsigned S_PEN  = 0;
  localparam int unsigned S_PG   = 1;
  localparam int unsigned S_DISC = 2;
  localparam int unsigned S_DET  = 3;
  localparam int unsigned S_CLS  = 4;
  localparam int unsigned S_ILIM = 5;
  localparam int unsigned S_RSVD = 6;
  localparam int unsigned S_SUP  = 7;

  // source bit inside each event group
  localparam int unsigned E_PWR_EN   = 0;
  localparam int unsigned E_PWR_PG   = 4;
  localparam int unsigned E_DET_DONE = 0;
  localparam int unsigned E_DET_CLS  = 4;
  localparam int unsigned E_FLT_ILIM = 0;
  localparam int unsigned E_FLT_DISC = 4;

  localparam int unsigned N_GRP = 4;
  localparam int unsigned G_PWR = 0;
  localparam int unsigned G_DET = 1;
  localparam int unsigned G_FLT = 2;
  localparam int unsigned G_SUP = 3;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] evt_q;
  logic [W-1:0] evt_d;
  logic         evt_ce;

  // a set pulse beats a simultaneous clear
  always_comb begin
    evt_ce = clr_i | (|set_i);
    if (clr_i) evt_d = set_i;
    else       evt_d = evt_q | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= '0;
    else if (evt_ce) evt_q <= evt_d;
  end

  assign q_o = evt_q;
endmodule

// File: rtl/irq_sum_map.sv
module irq_sum_map
  import irq_agg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]      pwr_i,
  input  logic [W-1:0]      det_i,
  input  logic [W-1:0]      flt_i,
  input  logic [W-1:0]      sup_i,
  output logic [DATA_W-1:0] sum_o
);
  always_comb begin
    sum_o         = '0;
    sum_o[S_PEN]  = pwr_i[E_PWR_EN];
    sum_o[S_PG]   = pwr_i[E_PWR_PG];
    sum_o[S_DISC] = flt_i[E_FLT_DISC];
    sum_o[S_DET]  = det_i[E_DET_DONE];
    sum_o[S_CLS]  = det_i[E_DET_CLS];
    sum_o[S_ILIM] = flt_i[E_FLT_ILIM];
    sum_o[S_RSVD] = 1'b0;
    sum_o[S_SUP]  = |sup_i;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_agg_pkg::*;
#(
  parameter logic EN_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_o,
  output logic              en_o,
  output logic              clr_o
);
  logic [DATA_W-1:0] mask_q, mask_d;
  logic              mask_ce;
  logic              en_q, en_d;
  logic              en_ce;

  always_comb begin
    mask_ce = wr_en && (addr == A_MASK);
    mask_d  = wdata;
    en_ce   = wr_en && (addr == A_CTRL);
    en_d    = wdata[CMD_BIT];
    clr_o   = wr_en && (addr == A_CLR) && wdata[CMD_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= EN_RST;
    end else begin
      if (mask_ce) mask_q <= mask_d;
      if (en_ce)   en_q   <= en_d;
    end
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned EVT_W     = 8,
  parameter int unsigned SYNC_STGS = 2,
  parameter logic        EN_RST    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  pwr_set,
  input  logic [EVT_W-1:0]  det_set,
  input  logic [EVT_W-1:0]  flt_set,
  input  logic [EVT_W-1:0]  sup_set,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_do,
  output logic              irq_oe
);
  localparam int unsigned PAD_W = (DATA_W > EVT_W) ? DATA_W - EVT_W : 0;

  logic              rst_s_n;
  logic [DATA_W-1:0] mask_q;
  logic              en_q;
  logic              clr_cmd;
  logic [DATA_W-1:0] sum_w;
  logic [EVT_W-1:0]  grp_set [N_GRP];
  logic [EVT_W-1:0]  grp_q   [N_GRP];
  logic [EVT_W-1:0]  pwr_q, det_q, flt_q, sup_q;

  irq_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  irq_ctrl_regs #(.EN_RST(EN_RST)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_en  (reg_wr_en),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .mask_o (mask_q),
    .en_o   (en_q),
    .clr_o  (clr_cmd)
  );

  assign grp_set[G_PWR] = pwr_set;
  assign grp_set[G_DET] = det_set;
  assign grp_set[G_FLT] = flt_set;
  assign grp_set[G_SUP] = sup_set;

  for (genvar g = 0; g < N_GRP; g++) begin : g_bank
    irq_evt_bank #(.W(EVT_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_s_n),
      .set_i (grp_set[g]),
      .clr_i (clr_cmd),
      .q_o   (grp_q[g])
    );
  end

  assign pwr_q = grp_q[G_PWR];
  assign det_q = grp_q[G_DET];
  assign flt_q = grp_q[G_FLT];
  assign sup_q = grp_q[G_SUP];

  irq_sum_map #(.W(EVT_W)) u_map (
    .pwr_i (pwr_q),
    .det_i (det_q),
    .flt_i (flt_q),
    .sup_i (sup_q),
    .sum_o (sum_w)
  );

  function automatic logic [DATA_W-1:0] widen(input logic [EVT_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < EVT_W && i < DATA_W; i++) r[i] = v[i];
    return r;
  endfunction

  always_comb begin
    unique case (reg_addr)
      A_SUM:   reg_rdata = sum_w;
      A_MASK:  reg_rdata = mask_q;
      A_CTRL:  reg_rdata = {en_q, {(DATA_W-1){1'b0}}};
      A_CLR:   reg_rdata = '0;
      A_PWR:   reg_rdata = widen(pwr_q);
      A_DET:   reg_rdata = widen(det_q);
      A_FLT:   reg_rdata = widen(flt_q);
      default: reg_rdata = widen(sup_q);
    endcase
  end

  assign irq_do = ~(|(sum_w & ~mask_q));
  assign irq_oe = en_q;

  if (PAD_W > 0) begin : g_pad_note
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [W-1:0]      pwr_set,
  input logic [W-1:0]      det_set,
  input logic [W-1:0]      flt_set,
  input logic [W-1:0]      sup_set,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] summary,
  input logic [DATA_W-1:0] mask,
  input logic [W-1:0]      pwr_q,
  input logic [W-1:0]      det_q,
  input logic [W-1:0]      flt_q,
  input logic [W-1:0]      sup_q,
  input logic              irq_do,
  input logic              irq_oe
);
  logic clr_req;
  logic no_set;
  assign clr_req = reg_wr_en && (reg_addr == A_CLR) && reg_wdata[CMD_BIT];
  assign no_set  = !(|pwr_set) && !(|det_set) && !(|flt_set) && !(|sup_set);

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> ((pwr_q & $past(pwr_q)) == $past(pwr_q)) && ((flt_q & $past(flt_q)) == $past(flt_q))); // R2

  AST_SUP_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (|sup_set) |=> summary[S_SUP]); // R3

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (summary == '0) |-> irq_do); // R4

  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> irq_do); // R5

  AST_PIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == A_CTRL && !reg_wdata[CMD_BIT]) |=> !irq_oe); // R6

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && no_set) |=> (summary == '0) && (pwr_q == '0) && (det_q == '0) && (flt_q == '0) && (sup_q == '0)); // R7

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && (|det_set)) |=> (det_q == $past(det_set))); // R8

  AST_SUM_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == A_SUM && no_set) |=> $stable(summary)); // R9
endmodule

bind irq_aggregator irq_aggregator_chk #(.W(EVT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .pwr_set   (pwr_set),
  .det_set   (det_set),
  .flt_set   (flt_set),
  .sup_set   (sup_set),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .summary   (sum_w),
  .mask      (mask_q),
  .pwr_q     (pwr_q),
  .det_q     (det_q),
  .flt_q     (flt_q),
  .sup_q     (sup_q),
  .irq_do    (irq_do),
  .irq_oe    (irq_oe)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] pwr_set, det_set, flt_set, sup_set;
  logic       reg_wr_en;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_do, irq_oe;

  int n_chk;
  int n_fail;

  irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n),
    .pwr_set(pwr_set), .det_set(det_set), .flt_set(flt_set), .sup_set(sup_set),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_do(irq_do), .irq_oe(irq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic pulse(input logic [7:0] p, input logic [7:0] de, input logic [7:0] f, input logic [7:0] s);
    @(negedge clk);
    pwr_set = p; det_set = de; flt_set = f; sup_set = s;
    @(negedge clk);
    pwr_set = 0; det_set = 0; flt_set = 0; sup_set = 0;
  endtask

  task automatic clear_all();
    wr(3'd3, 8'h80);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R1", $sformatf("reset addr %0d", a), d, (a == 2) ? 8'h80 : 8'h00);
    end
    chk("R1", "reset irq_do", {7'b0, irq_do}, 8'h01);
    chk("R1", "reset irq_oe", {7'b0, irq_oe}, 8'h01);
  endtask

  task automatic t_mapping();
    logic [7:0] d;
    // {group, bit, expected summary}
    logic [7:0] grp [6] = '{8'd0, 8'd0, 8'd2, 8'd1, 8'd1, 8'd2};
    logic [7:0] bitn[6] = '{8'd0, 8'd4, 8'd4, 8'd0, 8'd4, 8'd0};
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      clear_all();
      v = 8'h01 << bitn[i];
      pulse(grp[i] == 0 ? v : 8'h00, grp[i] == 1 ? v : 8'h00, grp[i] == 2 ? v : 8'h00, 8'h00);
      rd(3'd0, d);
      chk("R3", $sformatf("summary mirror %0d", i), d, 8'h01 << i);
      chk("R4", $sformatf("irq low mirror %0d", i), {7'b0, irq_do}, 8'h00);
    end
    clear_all();
    pulse(8'h02, 8'h80, 8'h04, 8'h00);
    rd(3'd0, d);
    chk("R3", "unmapped bits leave summary", d, 8'h00);
    chk("R4", "unmapped bits keep irq high", {7'b0, irq_do}, 8'h01);
    rd(3'd5, d);
    chk("R2", "unmapped detect bit stored", d, 8'h80);
    clear_all();
    pulse(8'h00, 8'h00, 8'h00, 8'h20);
    rd(3'd0, d);
    chk("R3", "supply OR to bit7, bit6 zero", d, 8'h80);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    clear_all();
    pulse(8'h01, 8'h00, 8'h00, 8'h00);
    pulse(8'h10, 8'h00, 8'h00, 8'h00);
    repeat (5) @(negedge clk);
    rd(3'd4, d);
    chk("R2", "power bits accumulate and hold", d, 8'h11);
    rd(3'd0, d);
    chk("R3", "summary of power bits", d, 8'h03);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    clear_all();
    pulse(8'h00, 8'h01, 8'h00, 8'h00);
    wr(3'd1, 8'h08);
    chk("R5", "masked det bit keeps irq high", {7'b0, irq_do}, 8'h01);
    rd(3'd0, d);
    chk("R5", "masked bit still in summary", d, 8'h08);
    pulse(8'h00, 8'h00, 8'h01, 8'h00);
    chk("R4", "unmasked ilim drives irq low", {7'b0, irq_do}, 8'h00);
    wr(3'd1, 8'hFF);
    chk("R5", "all masked irq high", {7'b0, irq_do}, 8'h01);
    wr(3'd1, 8'h00);
    chk("R4", "unmask irq low", {7'b0, irq_do}, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    wr(3'd2, 8'h7F);
    chk("R6", "enable 0 releases pin", {7'b0, irq_oe}, 8'h00);
    rd(3'd2, d);
    chk("R6", "ctrl readback disabled", d, 8'h00);
    wr(3'd2, 8'h80);
    chk("R6", "enable 1 drives pin", {7'b0, irq_oe}, 8'h01);
    rd(3'd2, d);
    chk("R6", "ctrl readback enabled", d, 8'h80);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    pulse(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    wr(3'd1, 8'h0F);
    wr(3'd3, 8'h7F);
    rd(3'd6, d);
    chk("R10", "clear without bit7 keeps fault", d, 8'hFF);
    clear_all();
    for (int a = 4; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R7", $sformatf("event addr %0d cleared", a), d, 8'h00);
    end
    rd(3'd0, d);
    chk("R7", "summary cleared", d, 8'h00);
    rd(3'd1, d);
    chk("R7", "mask kept", d, 8'h0F);
    rd(3'd2, d);
    chk("R7", "enable kept", d, 8'h80);
    rd(3'd3, d);
    chk("R7", "clear reads zero", d, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] d;
    pulse(8'h11, 8'h01, 8'h11, 8'h03);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h80; det_set = 8'h10;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = 8'h00; det_set = 8'h00;
    rd(3'd5, d);
    chk("R8", "pulsed detect bit survives clear", d, 8'h10);
    rd(3'd4, d);
    chk("R8", "power cleared", d, 8'h00);
    rd(3'd6, d);
    chk("R8", "fault cleared", d, 8'h00);
    rd(3'd7, d);
    chk("R8", "supply cleared", d, 8'h00);
    rd(3'd0, d);
    chk("R8", "summary only class bit", d, 8'h10);
    chk("R8", "irq still low", {7'b0, irq_do}, 8'h00);
  endtask

  task automatic t_readonly();
    logic [7:0] d;
    clear_all();
    pulse(8'h01, 8'h00, 8'h00, 8'h00);
    wr(3'd0, 8'hFF);
    for (int a = 4; a < 8; a++) wr(a[2:0], 8'hAA);
    rd(3'd0, d);
    chk("R9", "summary unchanged by writes", d, 8'h01);
    rd(3'd4, d);
    chk("R9", "power unchanged by write", d, 8'h01);
    rd(3'd5, d);
    chk("R9", "detect unchanged by write", d, 8'h00);
    rd(3'd7, d);
    chk("R9", "supply unchanged by write", d, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    pwr_set = 0; det_set = 0; flt_set = 0; sup_set = 0;
    reg_wr_en = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mapping();
    t_sticky();
    t_mask();
    t_enable();
    t_clear();
    t_race();
    t_readonly();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule